// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Bank

This block drives and observes a group of general-purpose pads through three registers on a simple single-cycle register bus. A mode register chooses, pin by pin, whether the pad is driven. A level register holds the value put on driven pads. A sense register returns the pin levels, which pass through a two-flop synchronizer first. Each pad has two outputs: a drive value and a drive enable.

The block has two kinds of reset. An asynchronous power-on reset and a hardware-standby input clear the mode and level registers. A manual reset and a software-standby input leave both registers as they are and refuse bus writes. Each pin also has a peripheral takeover input. When it is high, that peripheral's drive value and drive enable reach the pad in place of the register values. A manual reset switches every takeover off, so the pads then follow the two registers alone.

The bus is plain control access and has no back-pressure. A read returns data combinationally in the cycle that `rd_en` is high. A write takes effect at the clock edge on which `wr_en` is high. No valid/ready stream exists in this block.

Top module: `gpio_bank`

## Requirements
- R1: A write to address 0 (mode register) sets the drive enables. With no takeover active, `pad_oe` bit i equals mode bit i from the cycle after the write, and a 1 means driven.
- R2: A read of address 0 returns 0x00 whatever the mode register holds.
- R3: Address 1 (level register) is readable and writable. With no takeover, `pad_out` equals its contents. A read returns the stored value, not the pin level.
- R4: A read of address 2 (sense register) returns `pin_in` as sampled two clock edges earlier.
- R5: Writes to address 2 and address 3 change neither register.
- R6: While `por_n` is low, both registers are 0x00, and `pad_oe` and `pad_out` are 0x00.
- R7: While `hw_stby` is high, both registers are held at 0x00 and bus writes have no effect.
- R8: While `manual_rst` is high, both registers keep their contents and bus writes are ignored.
- R9: While `sw_stby` is high, both registers keep their contents and bus writes are ignored.
- R10: When `periph_en` bit i is high and `manual_rst` is low, `pad_out` bit i and `pad_oe` bit i take `periph_out` bit i and `periph_oe` bit i.
- R11: While `manual_rst` is high, `pad_out` equals the level register and `pad_oe` equals the mode register for every pin, whatever `periph_en` holds.
- R12: `rdata` is 0x00 when `rd_en` is low, and also on a read of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_stby | input | 1 | Hardware standby; clears the registers while high |
| manual_rst | input | 1 | Manual reset; keeps registers, disables takeover |
| sw_stby | input | 1 | Software standby; keeps registers, blocks writes |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pad input levels |
| periph_en | input | 8 | Per-pin peripheral takeover |
| periph_out | input | 8 | Peripheral drive values |
| periph_oe | input | 8 | Peripheral drive enables |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |

## Verification
The in-design assertions check five things on every cycle. A write to the mode register shows up on the unclaimed drive enables one cycle later. Both registers stay put while a manual reset or software standby is active, or after a write to the sense or unused address. A mode-register read returns zero. With the manual reset high, the pads follow the registers. Once two edges have passed since reset, the sense path equals the input from two edges before. The bench scenarios cover what the assertions do not: the clearing done by power-on reset and hardware standby, that stored values survive once a hold is released, the exact lag of a pin change, and how the takeover mixes per pin with register-driven pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MODE  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_SENSE = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] stage1_q, stage2_q;
  logic [1:0]       age_q;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          stage1_q[g] <= 1'b0;
          stage2_q[g] <= 1'b0;
        end else begin
          stage1_q[g] <= pin_in[g];
          stage2_q[g] <= stage1_q[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign pin_sync = stage2_q;

  // R4: the sense path lags the pads by exactly two edges
  a_r4_two_edge_lag: assert property (@(posedge clk) disable iff (!por_n)
    (age_q == 2'd2) |-> (pin_sync == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  pin_sync,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  level_q
);
  reg_sel_e sel;
  logic     wr_ok;

  assign sel   = reg_sel_e'(addr);
  assign wr_ok = wr_en && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      level_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_MODE:  mode_q  <= wdata;
        SEL_LEVEL: level_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_LEVEL: rdata = level_q;
        SEL_SENSE: rdata = pin_sync;
        default:   rdata = '0;
      endcase
    end
  end

  // R8 R9: a hold freezes both registers
  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(mode_q) && $stable(level_q)));
  // R5: sense and spare addresses take no writes
  a_r5_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_SENSE || sel == SEL_SPARE)) |=> ($stable(mode_q) && $stable(level_q)));
  // R2: the mode register reads as zero
  a_r2_mode_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_MODE) |-> (rdata == '0));
endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] claim,
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] level_q,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pad
      assign pad_out[g] = claim[g] ? periph_out[g] : level_q[g];
      assign pad_oe[g]  = claim[g] ? periph_oe[g]  : mode_q[g];
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_stby,
  input  logic              manual_rst,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  periph_en,
  input  logic [NPINS-1:0]  periph_out,
  input  logic [NPINS-1:0]  periph_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  logic             reg_rst_n;
  logic             hold;
  logic [NPINS-1:0] claim;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] mode_q, level_q;

  assign reg_rst_n = por_n && !hw_stby;
  assign hold      = manual_rst || sw_stby;
  assign claim     = periph_en & {NPINS{!manual_rst}};

  gpio_bank_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(reg_rst_n), .hold(hold), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .pin_sync(pin_sync),
    .rdata(rdata), .mode_q(mode_q), .level_q(level_q)
  );

  gpio_bank_padmux #(.NPINS(NPINS)) u_pad (
    .claim(claim), .mode_q(mode_q), .level_q(level_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R1: a mode write reaches the unclaimed drive enables next cycle
  a_r1_mode_to_oe: assert property (@(posedge clk) disable iff (!reg_rst_n)
    (wr_en && !hold && addr == SEL_MODE) |=>
      ((pad_oe & ~claim) == ($past(wdata) & ~claim)));
  // R11: manual reset leaves the pads to the registers
  a_r11_manual_regs_only: assert property (@(posedge clk) disable iff (!reg_rst_n)
    manual_rst |-> (pad_oe == mode_q && pad_out == level_q));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, hw_stby = 1'b0, manual_rst = 1'b0, sw_stby = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata, pin_in = '0;
  logic [7:0] periph_en = '0, periph_out = '0, periph_oe = '0;
  logic [7:0] pad_out, pad_oe;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .manual_rst(manual_rst),
    .sw_stby(sw_stby), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .periph_en(periph_en),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vector: {op[1:0], addr[1:0], data[7:0]}; op 0 write, 1 read, 2 pad_out, 3 pad_oe
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'h0F},  // R1 mode write
    {2'd0, 2'd1, 8'hA5},  // R3 level write
    {2'd2, 2'd0, 8'hA5},  // R3 pad_out follows level
    {2'd3, 2'd0, 8'h0F},  // R1 pad_oe follows mode
    {2'd1, 2'd0, 8'h00},  // R2 mode reads zero
    {2'd1, 2'd1, 8'hA5},  // R3 level readback
    {2'd0, 2'd1, 8'h3C},  // R3
    {2'd1, 2'd1, 8'h3C},  // R3
    {2'd2, 2'd0, 8'h3C},  // R3
    {2'd0, 2'd0, 8'hF0},  // R1
    {2'd3, 2'd0, 8'hF0},  // R1
    {2'd0, 2'd2, 8'hFF},  // R5 sense write
    {2'd1, 2'd1, 8'h3C},  // R5 level unchanged
    {2'd3, 2'd0, 8'hF0},  // R5 mode unchanged
    {2'd0, 2'd3, 8'h55},  // R5 spare write
    {2'd1, 2'd1, 8'h3C}   // R5 level unchanged
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    pin_in = 8'hC3;
    repeat (3) @(negedge clk);
    check("R6 pad_oe in reset", pad_oe, 8'h00);
    check("R6 pad_out in reset", pad_out, 8'h00);
    por_n = 1'b1;
    bus_read(2'd1, v); check("R6 level after reset", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [1:0] a; logic [7:0] d;
      {op, a, d} = VEC[i];
      case (op)
        2'd0: bus_write(a, d);
        2'd1: begin bus_read(a, v); check($sformatf("table %0d read", i), v, d); end
        2'd2: begin @(negedge clk); check($sformatf("table %0d pad_out", i), pad_out, d); end
        default: begin @(negedge clk); check($sformatf("table %0d pad_oe", i), pad_oe, d); end
      endcase
    end

    // R12 idle read and spare read
    @(negedge clk); addr = 2'd1; rd_en = 1'b0; #2;
    check("R12 idle rdata", rdata, 8'h00);
    bus_read(2'd3, v); check("R12 spare read", v, 8'h00);

    // R4 two-edge lag, R3 level read is not the pin
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; #2;
    check("R4 one edge later", rdata, 8'hC3);
    rd_en = 1'b0;
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; #2;
    check("R4 two edges later", rdata, 8'h5A);
    rd_en = 1'b0;
    bus_read(2'd1, v); check("R3 level not pin", v, 8'h3C);

    // R8 manual reset keeps and blocks
    bus_write(2'd0, 8'hFF); bus_write(2'd1, 8'h77);
    @(negedge clk); manual_rst = 1'b1;
    bus_write(2'd1, 8'h11);
    check("R8 pad_out held", pad_out, 8'h77);
    // R11 takeover forced off
    periph_en = 8'hFF; periph_out = 8'h00; periph_oe = 8'h00;
    @(negedge clk);
    check("R11 pad_out from level", pad_out, 8'h77);
    check("R11 pad_oe from mode", pad_oe, 8'hFF);
    manual_rst = 1'b0; periph_en = 8'h00;
    bus_read(2'd1, v); check("R8 level kept", v, 8'h77);

    // R9 software standby
    @(negedge clk); sw_stby = 1'b1;
    bus_write(2'd1, 8'h22); bus_write(2'd0, 8'h00);
    sw_stby = 1'b0;
    bus_read(2'd1, v); check("R9 level kept", v, 8'h77);
    @(negedge clk); check("R9 mode kept", pad_oe, 8'hFF);

    // R10 per-pin takeover
    bus_write(2'd0, 8'h00); bus_write(2'd1, 8'hFF);
    periph_en = 8'h03; periph_out = 8'h01; periph_oe = 8'h03;
    @(negedge clk);
    check("R10 pad_out mix", pad_out, 8'hFD);
    check("R10 pad_oe mix", pad_oe, 8'h03);
    periph_en = 8'h00;

    // R7 hardware standby clears and blocks
    @(negedge clk); hw_stby = 1'b1;
    bus_write(2'd1, 8'h99); bus_write(2'd0, 8'h99);
    check("R7 pad_out cleared", pad_out, 8'h00);
    check("R7 pad_oe cleared", pad_oe, 8'h00);
    hw_stby = 1'b0;
    bus_read(2'd1, v); check("R7 level cleared", v, 8'h00);

    // R6 power-on reset pulse
    bus_write(2'd0, 8'hAA); bus_write(2'd1, 8'h55);
    @(negedge clk); por_n = 1'b0; #2;
    check("R6 pad_oe cleared", pad_oe, 8'h00);
    check("R6 pad_out cleared", pad_out, 8'h00);
    @(negedge clk); por_n = 1'b1;
    bus_read(2'd1, v); check("R6 level cleared", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule